// File: doc/BRIEF.md
# Phase-Aware Host FIFO Port

This block sits behind the FIFO offset of a storage-bus controller's register file. It holds a small byte buffer that has its own read pointer, its own write pointer and a remaining-byte count. The register block supplies the current bus-phase bits and a command-collect flag. The host issues single-cycle read and write strobes, and the port decides where each access goes: to the command buffer, to the data path, or into the byte buffer.

A response loader puts a two-byte status/message pair into the buffer in one cycle, so the host can read it back through the same register. Whenever a read finds bytes remaining, the port pulses its interrupt output. A flush strobe brings the port back to empty.

Top module: `fifo_port`

## Requirements
- R1: After reset, rdata_o, rem_o, flags_o, cmd_len_o, ovf_o, irq_o, data_we_o and cmd_we_o are all zero, and every buffer entry is zero.
- R2: phase_i carries status bits 2:1. The value 2'b00 marks a data phase. Every other value is a non-data phase.
- R3: A read while rem_o is nonzero in a non-data phase has these effects. From the next cycle, rdata_o shows the byte at the read pointer. The read pointer advances by one and rem_o drops by one.
- R4: A read while rem_o is nonzero in a data phase has these effects. From the next cycle, rdata_o is 0 and rem_o drops by one. The read pointer does not move.
- R5: Each read made while rem_o is nonzero, and each response load, drives irq_o high for exactly the following cycle.
- R6: A read while rem_o is zero sets both pointers to zero. rdata_o and rem_o keep their values and no interrupt is raised.
- R7: While cmd_collect_i is set, a write pulses cmd_we_o in the next cycle. That cycle carries the byte in cmd_byte_o and the old length in cmd_idx_o, and cmd_len_o goes up by one. This happens in any phase.
- R8: With collect clear, a write in a data phase pulses data_we_o in the next cycle with the byte in data_byte_o. rem_o drops by one but does not go below zero.
- R9: With collect clear, a write in a non-data phase stores the byte at the write pointer and advances that pointer. rem_o is unchanged.
- R10: A response load writes the status byte to entry 0 and the message byte to entry 1. It sets rem_o to 2, clears both pointers and sets flags_o to 2.
- R11: A write is dropped when its target is full: the byte buffer when the write pointer equals DEPTH, the command buffer when cmd_len_o equals CMD_DEPTH. A dropped write sets ovf_o, which stays set until a flush.
- R12: A flush clears both pointers, rem_o, cmd_len_o and ovf_o in one cycle. It leaves flags_o and rdata_o as they are.
- R13: When strobes arrive in the same cycle, only one takes effect. The order of precedence is flush, then load, then read, then write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | Status bits 2:1 (bus phase) |
| cmd_collect_i | input | 1 | Send host writes to the command buffer |
| flush_i | input | 1 | Empty the port |
| rsp_load_i | input | 1 | Load the two-byte response |
| rsp_status_i | input | DATA_W | Status byte of the response |
| rsp_msg_i | input | DATA_W | Message byte of the response |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | DATA_W | Host write byte |
| rdata_o | output | DATA_W | FIFO register value |
| irq_o | output | 1 | Interrupt pulse |
| data_we_o | output | 1 | Byte passed to the data path |
| data_byte_o | output | DATA_W | Data-path byte |
| cmd_we_o | output | 1 | Command-buffer write strobe |
| cmd_idx_o | output | CIDX_W | Command-buffer write index |
| cmd_byte_o | output | DATA_W | Command-buffer byte |
| cmd_len_o | output | CLEN_W | Command length |
| rem_o | output | REM_W | Remaining-byte count |
| flags_o | output | DATA_W | FIFO-flags value |
| ovf_o | output | 1 | Sticky overflow |

## Verification
Every output comes from a register. The result of a strobe presented during cycle N therefore shows up immediately after the clock edge that ends cycle N, and nowhere sooner or later. The bench drives inputs just after a rising edge. Its reference model advances when the next edge arrives, and all ports are compared one time unit after that edge. The comparison therefore lands in the only cycle where the result is due. Because the irq, data and command strobes last one cycle, each is checked for being high in that cycle and low in every other.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FLUSH,
    OP_LOAD,
    OP_RD,
    OP_WR
  } op_e;

  function automatic logic is_data_phase(input logic [1:0] ph);
    return ph == 2'b00;
  endfunction
endpackage

// File: rtl/fp_store.sv
module fp_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              ld_en_i,
  input  logic [DATA_W-1:0] ld_b0_i,
  input  logic [DATA_W-1:0] ld_b1_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_byte_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              ld_hit;
    logic [DATA_W-1:0] ld_val;
    if (i == 0) begin : g_b0
      assign ld_hit = ld_en_i;
      assign ld_val = ld_b0_i;
    end else if (i == 1) begin : g_b1
      assign ld_hit = ld_en_i;
      assign ld_val = ld_b1_i;
    end else begin : g_bn
      assign ld_hit = 1'b0;
      assign ld_val = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (ld_hit)                             mem_q[i] <= ld_val;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))   mem_q[i] <= wr_byte_i;
    end
  end

  assign rd_byte_o = mem_q[rd_idx_i];
endmodule

// File: rtl/fp_track.sv
module fp_track
  import fifo_port_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REM_W  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              data_ph_i,
  input  logic              collect_i,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [REM_W-1:0]  rem_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              buf_we_o,
  output logic              ovf_o,
  output logic              rd_hit_o
);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(DEPTH);
  localparam logic [REM_W-1:0] RSP_LEN  = REM_W'(2);

  logic [PTR_W-1:0]  rptr_q, rptr_d, wptr_q, wptr_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [DATA_W-1:0] flags_q, flags_d;
  logic              nd_wr;

  assign nd_wr    = (op_i == OP_WR) && !collect_i && !data_ph_i;
  assign buf_we_o = nd_wr && (wptr_q != PTR_FULL);
  assign ovf_o    = nd_wr && (wptr_q == PTR_FULL);
  assign rd_hit_o = (op_i == OP_RD) && (rem_q != '0);

  always_comb begin
    rptr_d  = rptr_q;
    wptr_d  = wptr_q;
    rem_d   = rem_q;
    flags_d = flags_q;
    unique case (op_i)
      OP_FLUSH: begin
        rptr_d = '0;
        wptr_d = '0;
        rem_d  = '0;
      end
      OP_LOAD: begin
        rptr_d  = '0;
        wptr_d  = '0;
        rem_d   = RSP_LEN;
        flags_d = DATA_W'(2);
      end
      OP_RD: begin
        if (rem_q != '0) begin
          rem_d = rem_q - 1'b1;
          if (!data_ph_i && rptr_q != PTR_FULL) rptr_d = rptr_q + 1'b1;
        end else begin
          rptr_d = '0;
          wptr_d = '0;
        end
      end
      OP_WR: begin
        if (!collect_i) begin
          if (data_ph_i) begin
            if (rem_q != '0) rem_d = rem_q - 1'b1;
          end else if (buf_we_o) begin
            wptr_d = wptr_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      rem_q   <= '0;
      flags_q <= '0;
    end else begin
      rptr_q  <= rptr_d;
      wptr_q  <= wptr_d;
      rem_q   <= rem_d;
      flags_q <= flags_d;
    end
  end

  assign rptr_o  = rptr_q;
  assign wptr_o  = wptr_q;
  assign rem_o   = rem_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/fp_cmd.sv
module fp_cmd
  import fifo_port_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int DATA_W    = 8,
  localparam int CLEN_W   = $clog2(CMD_DEPTH + 1),
  localparam int CIDX_W   = $clog2(CMD_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              collect_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cmd_we_o,
  output logic [CIDX_W-1:0] cmd_idx_o,
  output logic [DATA_W-1:0] cmd_byte_o,
  output logic [CLEN_W-1:0] cmd_len_o,
  output logic              ovf_o
);
  localparam logic [CLEN_W-1:0] LEN_FULL = CLEN_W'(CMD_DEPTH);

  logic [CLEN_W-1:0] len_q;
  logic              cw, acc;

  assign cw    = (op_i == OP_WR) && collect_i;
  assign acc   = cw && (len_q != LEN_FULL);
  assign ovf_o = cw && (len_q == LEN_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= '0;
      cmd_we_o   <= 1'b0;
      cmd_idx_o  <= '0;
      cmd_byte_o <= '0;
    end else begin
      cmd_we_o <= acc;
      if (op_i == OP_FLUSH) begin
        len_q <= '0;
      end else if (acc) begin
        len_q      <= len_q + 1'b1;
        cmd_idx_o  <= len_q[CIDX_W-1:0];
        cmd_byte_o <= wdata_i;
      end
    end
  end

  assign cmd_len_o = len_q;
endmodule

// File: rtl/fifo_port.sv
module fifo_port
  import fifo_port_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int DATA_W    = 8,
  parameter int REM_W     = 8,
  localparam int CLEN_W   = $clog2(CMD_DEPTH + 1),
  localparam int CIDX_W   = $clog2(CMD_DEPTH),
  localparam int PTR_W    = $clog2(DEPTH + 1),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        phase_i,
  input  logic              cmd_collect_i,
  input  logic              flush_i,
  input  logic              rsp_load_i,
  input  logic [DATA_W-1:0] rsp_status_i,
  input  logic [DATA_W-1:0] rsp_msg_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              data_we_o,
  output logic [DATA_W-1:0] data_byte_o,
  output logic              cmd_we_o,
  output logic [CIDX_W-1:0] cmd_idx_o,
  output logic [DATA_W-1:0] cmd_byte_o,
  output logic [CLEN_W-1:0] cmd_len_o,
  output logic [REM_W-1:0]  rem_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              ovf_o
);
  op_e               op;
  logic              data_ph;
  logic [PTR_W-1:0]  rptr, wptr;
  logic              buf_we, buf_ovf, cmd_ovf, rd_hit;
  logic [DATA_W-1:0] rd_byte;
  logic              data_wr;

  // one strobe wins per cycle
  always_comb begin
    if (flush_i)         op = OP_FLUSH;
    else if (rsp_load_i) op = OP_LOAD;
    else if (rd_i)       op = OP_RD;
    else if (wr_i)       op = OP_WR;
    else                 op = OP_IDLE;
  end

  assign data_ph = is_data_phase(phase_i);
  assign data_wr = (op == OP_WR) && !cmd_collect_i && data_ph;

  fp_track #(.DEPTH(DEPTH), .REM_W(REM_W), .DATA_W(DATA_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .data_ph_i (data_ph),
    .collect_i (cmd_collect_i),
    .rptr_o    (rptr),
    .wptr_o    (wptr),
    .rem_o     (rem_o),
    .flags_o   (flags_o),
    .buf_we_o  (buf_we),
    .ovf_o     (buf_ovf),
    .rd_hit_o  (rd_hit)
  );

  fp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (buf_we),
    .wr_idx_i  (wptr[IDX_W-1:0]),
    .wr_byte_i (wdata_i),
    .ld_en_i   (op == OP_LOAD),
    .ld_b0_i   (rsp_status_i),
    .ld_b1_i   (rsp_msg_i),
    .rd_idx_i  (rptr[IDX_W-1:0]),
    .rd_byte_o (rd_byte)
  );

  fp_cmd #(.CMD_DEPTH(CMD_DEPTH), .DATA_W(DATA_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .collect_i  (cmd_collect_i),
    .wdata_i    (wdata_i),
    .cmd_we_o   (cmd_we_o),
    .cmd_idx_o  (cmd_idx_o),
    .cmd_byte_o (cmd_byte_o),
    .cmd_len_o  (cmd_len_o),
    .ovf_o      (cmd_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      irq_o       <= 1'b0;
      data_we_o   <= 1'b0;
      data_byte_o <= '0;
      ovf_o       <= 1'b0;
    end else begin
      irq_o     <= rd_hit || (op == OP_LOAD);
      data_we_o <= data_wr;
      if (rd_hit)  rdata_o <= data_ph ? '0 : rd_byte;
      if (data_wr) data_byte_o <= wdata_i;
      if (op == OP_FLUSH)          ovf_o <= 1'b0;
      else if (buf_ovf || cmd_ovf) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_port_chk.sv
module fifo_port_chk #(
  parameter int DATA_W = 8,
  parameter int REM_W  = 8,
  parameter int CLEN_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        phase_i,
  input logic              cmd_collect_i,
  input logic              flush_i,
  input logic              rsp_load_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              cmd_we_o,
  input logic [CLEN_W-1:0] cmd_len_o,
  input logic [REM_W-1:0]  rem_o,
  input logic [DATA_W-1:0] flags_o,
  input logic              ovf_o
);
  logic solo_rd, solo_wr;
  assign solo_rd = rd_i && !flush_i && !rsp_load_i;
  assign solo_wr = wr_i && !rd_i && !flush_i && !rsp_load_i;

  a_r5_read_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_rd && rem_o != '0) |=> irq_o);

  a_r4_data_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_rd && rem_o != '0 && phase_i == 2'b00) |=> rdata_o == '0);

  a_r6_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_rd && rem_o == '0) |=> (!irq_o && $stable(rdata_o) && rem_o == '0));

  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_load_i && !flush_i) |=> (rem_o == REM_W'(2) && flags_o == DATA_W'(2) && irq_o));

  a_r12_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (rem_o == '0 && cmd_len_o == '0 && !ovf_o));

  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flush_i) |=> ovf_o);

  a_r7_cmd_append: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_wr && cmd_collect_i && !cmd_we_o && !ovf_o && cmd_len_o == '0)
      |=> (cmd_we_o && cmd_len_o == CLEN_W'(1)));

  a_r8_data_wr_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_wr && !cmd_collect_i && phase_i == 2'b00 && rem_o != '0)
      |=> rem_o == $past(rem_o) - 1'b1);
endmodule

bind fifo_port fifo_port_chk #(.DATA_W(DATA_W), .REM_W(REM_W), .CLEN_W(CLEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .phase_i       (phase_i),
  .cmd_collect_i (cmd_collect_i),
  .flush_i       (flush_i),
  .rsp_load_i    (rsp_load_i),
  .rd_i          (rd_i),
  .wr_i          (wr_i),
  .rdata_o       (rdata_o),
  .irq_o         (irq_o),
  .cmd_we_o      (cmd_we_o),
  .cmd_len_o     (cmd_len_o),
  .rem_o         (rem_o),
  .flags_o       (flags_o),
  .ovf_o         (ovf_o)
);

// File: tb/tb_fifo_port.sv
`timescale 1ns/1ps
module tb_fifo_port;
  localparam int DEPTH = 16, CMD_DEPTH = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] phase_i = 2'b11;
  logic       cmd_collect_i = 1'b0, flush_i = 1'b0, rsp_load_i = 1'b0;
  logic [7:0] rsp_status_i = '0, rsp_msg_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, data_byte_o, cmd_byte_o, flags_o;
  logic       irq_o, data_we_o, cmd_we_o, ovf_o;
  logic [3:0] cmd_idx_o;
  logic [4:0] cmd_len_o;
  logic [7:0] rem_o;

  fifo_port dut (.*);

  always #4 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int mbuf[DEPTH];
  int mr, mw, mrem, mflags, mlen, movf, mrdata;
  int e_irq, e_dwe, e_dbyte, e_cwe, e_cidx, e_cbyte;

  task automatic chk(string tag, string nm, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk(tag, "rdata", rdata_o, mrdata);
    chk(tag, "irq", irq_o, e_irq);
    chk(tag, "rem", rem_o, mrem);
    chk(tag, "flags", flags_o, mflags);
    chk(tag, "cmd_len", cmd_len_o, mlen);
    chk(tag, "ovf", ovf_o, movf);
    chk(tag, "data_we", data_we_o, e_dwe);
    chk(tag, "cmd_we", cmd_we_o, e_cwe);
    if (e_dwe != 0) chk(tag, "data_byte", data_byte_o, e_dbyte);
    if (e_cwe != 0) begin
      chk(tag, "cmd_idx", cmd_idx_o, e_cidx);
      chk(tag, "cmd_byte", cmd_byte_o, e_cbyte);
    end
  endtask

  // R2: data phase is phase_i == 2'b00
  task automatic step(string tag);
    bit dph;
    dph = (phase_i == 2'b00);
    e_irq = 0; e_dwe = 0; e_cwe = 0;
    if (flush_i) begin
      mr = 0; mw = 0; mrem = 0; mlen = 0; movf = 0;
    end else if (rsp_load_i) begin
      mbuf[0] = rsp_status_i; mbuf[1] = rsp_msg_i;
      mr = 0; mw = 0; mrem = 2; mflags = 2; e_irq = 1;
    end else if (rd_i) begin
      if (mrem > 0) begin
        mrem--; e_irq = 1;
        if (dph) mrdata = 0;
        else begin
          mrdata = mbuf[mr % DEPTH];
          if (mr < DEPTH) mr++;
        end
      end else begin
        mr = 0; mw = 0;
      end
    end else if (wr_i) begin
      if (cmd_collect_i) begin
        if (mlen < CMD_DEPTH) begin
          e_cwe = 1; e_cidx = mlen; e_cbyte = wdata_i; mlen++;
        end else movf = 1;
      end else if (dph) begin
        e_dwe = 1; e_dbyte = wdata_i;
        if (mrem > 0) mrem--;
      end else if (mw < DEPTH) begin
        mbuf[mw] = wdata_i; mw++;
      end else movf = 1;
    end
    @(posedge clk_i);
    #1;
    cmp(tag);
    flush_i = 0; rsp_load_i = 0; rd_i = 0; wr_i = 0;
  endtask

  task automatic t_idle(string tag); step(tag); endtask
  task automatic t_flush(string tag); flush_i = 1; step(tag); endtask
  task automatic t_load(string tag, int s, int m);
    rsp_load_i = 1; rsp_status_i = 8'(s); rsp_msg_i = 8'(m); step(tag);
  endtask
  task automatic t_rd(string tag); rd_i = 1; step(tag); endtask
  task automatic t_wr(string tag, int b); wr_i = 1; wdata_i = 8'(b); step(tag); endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mbuf[i] = 0;
    mr = 0; mw = 0; mrem = 0; mflags = 0; mlen = 0; movf = 0; mrdata = 0;
    e_irq = 0; e_dwe = 0; e_cwe = 0; e_dbyte = 0; e_cidx = 0; e_cbyte = 0;
    #20;
    cmp("R1");
    @(posedge clk_i); #1;
    rst_ni = 1;
    t_idle("R1");

    // R10 / R3 / R5: load then read in a non-data phase
    phase_i = 2'b11;
    t_load("R10", 8'hA5, 8'h3C);
    t_rd("R3");
    t_rd("R3");
    // R6: empty read keeps rdata, no irq
    t_rd("R6");
    t_idle("R5");

    // R9: writes land at the write pointer after a load
    t_flush("R12");
    phase_i = 2'b01;
    t_load("R10", 8'h11, 8'h22);
    t_wr("R9", 8'h77);
    t_wr("R9", 8'h88);
    t_rd("R9");
    t_rd("R9");

    // R4: data-phase read returns 0, read pointer kept
    t_load("R4", 8'h5A, 8'hC3);
    phase_i = 2'b00;
    t_rd("R4");
    phase_i = 2'b10;
    t_rd("R4");

    // R8: data-phase writes, count saturates at zero
    t_load("R8", 8'h01, 8'h02);
    phase_i = 2'b00;
    t_wr("R8", 8'h55);
    t_wr("R8", 8'h66);
    t_wr("R8", 8'h99);
    t_rd("R8");

    // R7 / R11: command collection to full then overflow
    t_flush("R12");
    cmd_collect_i = 1;
    for (int i = 0; i < CMD_DEPTH; i++) begin
      phase_i = 2'(i);
      t_wr("R7", 8'h40 + i);
    end
    t_wr("R11", 8'hEE);
    t_idle("R11");
    t_flush("R12");
    cmd_collect_i = 0;

    // R11 / R6: fill buffer, overflow, empty read resets pointers
    phase_i = 2'b11;
    for (int i = 0; i < DEPTH; i++) t_wr("R9", 8'h10 + i);
    t_wr("R11", 8'hBB);
    t_flush("R12");
    for (int i = 0; i < DEPTH; i++) t_wr("R9", 8'h20 + i);
    t_rd("R6");
    t_wr("R6", 8'hCD);
    t_idle("R6");
    t_load("R6", 8'hF0, 8'h0F);
    t_rd("R6");

    // R13: precedence
    flush_i = 1; rsp_load_i = 1; rsp_status_i = 8'h12; rsp_msg_i = 8'h34;
    step("R13");
    t_load("R13", 8'h61, 8'h62);
    rsp_load_i = 1; rsp_status_i = 8'h71; rsp_msg_i = 8'h72; rd_i = 1;
    step("R13");
    rd_i = 1; wr_i = 1; wdata_i = 8'hAB;
    step("R13");
    t_rd("R13");
    t_idle("R13");
    flush_i = 1; wr_i = 1; wdata_i = 8'h5F;
    step("R13");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule